// File: doc/BRIEF.md
# Parameter Page Validator for Flash Devices

This block checks the self-description page that a flash device returns during bring-up. The page reaches the block one byte per cycle in which `pg_valid` is high. As the bytes arrive the block runs a CRC-16 over the covered window. It also compares the leading bytes against the four-character signature and picks the geometry fields out of the stream at their fixed byte positions. The products it needs are formed while the rest of the page is still arriving. When the last byte of the page is accepted, a one-cycle `done` pulse appears together with the verdict and the decoded geometry.

A second, independent path checks the four-byte response to an identification read issued at address 0x20. The same four-character signature must appear there. The host uses `id_onfi` to decide whether a parameter page is worth fetching at all. The host's controller drives the flash bus, and this block only watches the returned bytes.

Top module: `onfi_param_validator`

## Requirements
- R1: After reset, `done`, `page_ok`, `sig_ok`, `crc_ok`, `bus16`, `page_bytes`, `block_bytes`, `total_bytes`, `ecc_known`, `ecc_bits`, `id_done` and `id_onfi` are all zero.
- R2: The CRC seed is 0x4F4E and the polynomial is 0x8005. Bytes 0 to 253 are fed most significant bit first, with no reflection and no final XOR. `crc_ok` is 1 when the result equals the stored value, which has its low byte at 254 and its high byte at 255.
- R3: `sig_ok` is 1 exactly when bytes 0..3 are 0x4F, 0x4E, 0x46, 0x49 ("ONFI").
- R4: `page_ok` is `sig_ok` AND `crc_ok`. On a rejected page, `bus16`, `page_bytes`, `block_bytes`, `total_bytes`, `ecc_known` and `ecc_bits` all report zero.
- R5: `done` is high for exactly one cycle, namely the cycle after the edge that accepts the last byte. All page outputs take their new values in that cycle and hold them until the next `done`.
- R6: `bus16` is bit 0 of byte 6.
- R7: `page_bytes` is the little-endian 32-bit field at bytes 80..83. `block_bytes` is `page_bytes` times the pages-per-block field, a little-endian 32-bit value at bytes 92..95.
- R8: `total_bytes` is `block_bytes` times blocks per unit (little-endian 32-bit at bytes 96..99) times the unit count (byte 100), kept modulo 2^SIZE_W.
- R9: When byte 112 is 0xFF, `ecc_known` is 0 and `ecc_bits` is 0. Any other value sets `ecc_known` to 1 and gives the correctable bits per 512-byte sector in `ecc_bits`.
- R10: The fourth accepted `id_byte` is followed one cycle later by a single-cycle `id_done` pulse. In that same cycle `id_onfi` becomes 1 exactly when the four bytes were 0x4F, 0x4E, 0x46, 0x49 in order, and it holds until the next pulse.
- R11: Cycles with `pg_valid` or `id_valid` low are ignored whatever the data bytes carry. After the last byte the page position wraps, so the next page is evaluated from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_valid | input | 1 | Page byte strobe |
| pg_byte | input | 8 | Page byte |
| id_valid | input | 1 | Identification byte strobe |
| id_byte | input | 8 | Identification byte |
| done | output | 1 | One-cycle page-complete pulse |
| page_ok | output | 1 | Page accepted |
| sig_ok | output | 1 | Page signature matched |
| crc_ok | output | 1 | Page CRC matched |
| bus16 | output | 1 | Device uses a 16-bit data bus |
| page_bytes | output | 32 | Data bytes per page |
| block_bytes | output | SIZE_W | Bytes per erase block |
| total_bytes | output | SIZE_W | Device capacity in bytes |
| ecc_known | output | 1 | ECC requirement specified |
| ecc_bits | output | 8 | Correctable bits per 512 bytes |
| id_done | output | 1 | One-cycle identification-complete pulse |
| id_onfi | output | 1 | Identification response matched signature |

## Verification
The bench builds the block with its defaults: PAGE_LEN of 256 and SIZE_W of 64. With a 256-byte page, the real 254-byte CRC window, the stored CRC at the tail and every field position used by the decoder are all exercised. With 64-bit sizes, the largest 32-bit fields yield a full-width block product and a wrapped total, which the bench predicts. Pages are streamed both back to back and with random idle gaps that carry junk data. They are corrupted in the signature, the stored CRC or the covered body. Identification words fail at each position in turn.

// File: rtl/onfi_pv_pkg.sv
// Shared constants and the CRC byte-step function for the parameter page
// validator. Field positions follow the page layout the decoder relies on.
package onfi_pv_pkg;

    localparam logic [31:0] SIG_WORD = 32'h4F4E_4649; // "ONFI", first char in MSB
    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_SEED = 16'h4F4E;
    localparam logic [7:0]  ECC_NONE = 8'hFF;

    localparam int FEAT_POS = 6;
    localparam int BPP_POS  = 80;
    localparam int PPB_POS  = 92;
    localparam int BPL_POS  = 96;
    localparam int LUN_POS  = 100;
    localparam int ECC_POS  = 112;

    // Advance a CRC-16 by one byte, most significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                             input logic [7:0]  data,
                                             input logic [15:0] poly);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 7; b >= 0; b--) begin
            fb = c[15] ^ data[b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/onfi_crc16_acc.sv
// Byte-wide CRC-16 accumulator. On each enabled cycle it absorbs one byte.
// When 'first' is set, it restarts from SEED before absorbing.
// Assumes the caller gates 'en' to the covered window.
module onfi_crc16_acc
    import onfi_pv_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h8005,
    parameter logic [15:0] SEED = 16'h4F4E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        first,
    input  logic [7:0]  data,
    output logic [15:0] crc
);

    logic [15:0] crc_base;

    // Pick the starting value for this byte.
    always_comb crc_base = first ? SEED : crc;

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)  crc <= SEED;
        else if (en) crc <= crc_step(crc_base, data, POLY);
    end

endmodule

// File: rtl/onfi_sig_match.sv
// Compares a byte stream against an N-character word, one position per
// enabled cycle. 'match_now' includes the current byte. 'ok_q' holds the
// verdict over all positions seen so far. Position 0 restarts the compare.
module onfi_sig_match #(
    parameter int             N   = 4,
    parameter int             PW  = 2,
    parameter logic [8*N-1:0] SIG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] pos,
    input  logic [7:0]    data,
    output logic          ok_q,
    output logic          match_now
);

    logic [7:0] exp_c;

    // Select the expected character and combine with prior positions.
    always_comb begin
        exp_c     = SIG[8*(N-1-int'(pos)) +: 8];
        match_now = ((pos == '0) ? 1'b1 : ok_q) && (data == exp_c);
    end

    // Record the running compare result.
    always_ff @(posedge clk) begin
        if (!rst_n)  ok_q <= 1'b0;
        else if (en) ok_q <= match_now;
    end

endmodule

// File: rtl/onfi_field_grab.sv
// Captures a little-endian multi-byte field from a byte stream. Bytes are
// taken when the stream position falls within [POS, POS+NBYTES).
module onfi_field_grab #(
    parameter int POS    = 0,
    parameter int NBYTES = 1,
    parameter int IDX_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [IDX_W-1:0]    idx,
    input  logic [7:0]          data,
    output logic [8*NBYTES-1:0] value
);

    // Drop each byte into its lane when its position comes by.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (idx == IDX_W'(POS + b)) value[8*b +: 8] <= data;
            end
        end
    end

endmodule

// File: rtl/onfi_param_validator.sv
// Streaming validator for a device parameter page plus an identification
// word check. Assumes PAGE_LEN > ECC_POS and that one byte arrives per
// cycle with pg_valid high. Products are formed in stages mid-page.
// Results are published with a one-cycle done pulse after the last byte.
module onfi_param_validator
    import onfi_pv_pkg::*;
#(
    parameter int PAGE_LEN = 256,
    parameter int SIZE_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_valid,
    input  logic [7:0]        pg_byte,
    input  logic              id_valid,
    input  logic [7:0]        id_byte,
    output logic              done,
    output logic              page_ok,
    output logic              sig_ok,
    output logic              crc_ok,
    output logic              bus16,
    output logic [31:0]       page_bytes,
    output logic [SIZE_W-1:0] block_bytes,
    output logic [SIZE_W-1:0] total_bytes,
    output logic              ecc_known,
    output logic [7:0]        ecc_bits,
    output logic              id_done,
    output logic              id_onfi
);

    localparam int IDX_W        = $clog2(PAGE_LEN);
    localparam int CRC_LO_POS   = PAGE_LEN - 2;
    localparam int SIG_N        = 4;
    localparam int SIG_W        = $clog2(SIG_N);
    localparam int BLK_STAGE    = PPB_POS + 4;
    localparam int LUNBLK_STAGE = LUN_POS + 1;
    localparam int TOTAL_STAGE  = LUN_POS + 2;

    logic [IDX_W-1:0]  idx;
    logic              last_byte;
    logic              in_crc_win;
    logic              in_sig_win;
    logic [15:0]       crc_q;
    logic [15:0]       crc_stored;
    logic              crc_match;
    logic              pg_sig_q;
    logic              pg_sig_now;
    logic              feat_bit;
    logic [31:0]       bpp_q;
    logic [31:0]       ppb_q;
    logic [31:0]       bpl_q;
    logic [7:0]        lun_q;
    logic [7:0]        ecc_q;
    logic [7:0]        crc_lo_q;
    logic [SIZE_W-1:0] block_q;
    logic [SIZE_W-1:0] lunblk_q;
    logic [SIZE_W-1:0] total_q;
    logic [SIG_W-1:0]  id_idx;
    logic              id_last;
    logic              id_sig_q;
    logic              id_match;
    logic              accept;

    // Decode the current stream position.
    always_comb begin
        last_byte  = pg_valid && (idx == IDX_W'(PAGE_LEN - 1));
        in_crc_win = idx < IDX_W'(CRC_LO_POS);
        in_sig_win = idx < IDX_W'(SIG_N);
        id_last    = id_valid && (id_idx == SIG_W'(SIG_N - 1));
    end

    // Page position counter, wrapping after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        idx <= '0;
        else if (last_byte) idx <= '0;
        else if (pg_valid)  idx <= idx + 1'b1;
    end

    onfi_crc16_acc #(
        .POLY (CRC_POLY),
        .SEED (CRC_SEED)
    ) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pg_valid && in_crc_win),
        .first (idx == '0),
        .data  (pg_byte),
        .crc   (crc_q)
    );

    onfi_sig_match #(
        .N   (SIG_N),
        .PW  (SIG_W),
        .SIG (SIG_WORD)
    ) u_pg_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (pg_valid && in_sig_win),
        .pos       (idx[SIG_W-1:0]),
        .data      (pg_byte),
        .ok_q      (pg_sig_q),
        .match_now (pg_sig_now)
    );

    onfi_sig_match #(
        .N   (SIG_N),
        .PW  (SIG_W),
        .SIG (SIG_WORD)
    ) u_id_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (id_valid),
        .pos       (id_idx),
        .data      (id_byte),
        .ok_q      (id_sig_q),
        .match_now (id_match)
    );

    onfi_field_grab #(.POS(BPP_POS), .NBYTES(4), .IDX_W(IDX_W)) u_bpp (
        .clk(clk), .rst_n(rst_n), .en(pg_valid), .idx(idx), .data(pg_byte), .value(bpp_q));
    onfi_field_grab #(.POS(PPB_POS), .NBYTES(4), .IDX_W(IDX_W)) u_ppb (
        .clk(clk), .rst_n(rst_n), .en(pg_valid), .idx(idx), .data(pg_byte), .value(ppb_q));
    onfi_field_grab #(.POS(BPL_POS), .NBYTES(4), .IDX_W(IDX_W)) u_bpl (
        .clk(clk), .rst_n(rst_n), .en(pg_valid), .idx(idx), .data(pg_byte), .value(bpl_q));
    onfi_field_grab #(.POS(LUN_POS), .NBYTES(1), .IDX_W(IDX_W)) u_lun (
        .clk(clk), .rst_n(rst_n), .en(pg_valid), .idx(idx), .data(pg_byte), .value(lun_q));
    onfi_field_grab #(.POS(ECC_POS), .NBYTES(1), .IDX_W(IDX_W)) u_ecc (
        .clk(clk), .rst_n(rst_n), .en(pg_valid), .idx(idx), .data(pg_byte), .value(ecc_q));
    onfi_field_grab #(.POS(CRC_LO_POS), .NBYTES(1), .IDX_W(IDX_W)) u_crclo (
        .clk(clk), .rst_n(rst_n), .en(pg_valid), .idx(idx), .data(pg_byte), .value(crc_lo_q));

    // Bus-width flag from the features byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       feat_bit <= 1'b0;
        else if (pg_valid && idx == IDX_W'(FEAT_POS))     feat_bit <= pg_byte[0];
    end

    // Staged geometry products, each formed once its operands are complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q  <= '0;
            lunblk_q <= '0;
            total_q  <= '0;
        end else if (pg_valid) begin
            if (idx == IDX_W'(BLK_STAGE))    block_q  <= SIZE_W'(bpp_q) * SIZE_W'(ppb_q);
            if (idx == IDX_W'(LUNBLK_STAGE)) lunblk_q <= SIZE_W'(bpl_q) * SIZE_W'(lun_q);
            if (idx == IDX_W'(TOTAL_STAGE))  total_q  <= block_q * lunblk_q;
        end
    end

    // Stored CRC is the captured low byte plus the incoming last byte.
    always_comb begin
        crc_stored = {pg_byte, crc_lo_q};
        crc_match  = (crc_q == crc_stored);
        accept     = pg_sig_q && crc_match;
    end

    // Publish the page verdict and geometry at the end of the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            page_ok     <= 1'b0;
            sig_ok      <= 1'b0;
            crc_ok      <= 1'b0;
            bus16       <= 1'b0;
            page_bytes  <= '0;
            block_bytes <= '0;
            total_bytes <= '0;
            ecc_known   <= 1'b0;
            ecc_bits    <= '0;
        end else begin
            done <= last_byte;
            if (last_byte) begin
                sig_ok      <= pg_sig_q;
                crc_ok      <= crc_match;
                page_ok     <= accept;
                bus16       <= accept && feat_bit;
                page_bytes  <= accept ? bpp_q : '0;
                block_bytes <= accept ? block_q : '0;
                total_bytes <= accept ? total_q : '0;
                ecc_known   <= accept && (ecc_q != ECC_NONE);
                ecc_bits    <= (accept && ecc_q != ECC_NONE) ? ecc_q : '0;
            end
        end
    end

    // Identification word position counter and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_idx  <= '0;
            id_done <= 1'b0;
            id_onfi <= 1'b0;
        end else begin
            id_done <= id_last;
            if (id_valid) id_idx <= id_idx + 1'b1;
            if (id_last)  id_onfi <= id_match;
        end
    end

    // The running signature state of the ID path is folded into id_match.
    logic unused_ok;
    always_comb unused_ok = id_sig_q ^ pg_sig_now;

endmodule

// File: rtl/onfi_param_validator_chk.sv
// Temporal checks on the validator's ports, attached through bind.
module onfi_param_validator_chk #(
    parameter int SIZE_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pg_valid,
    input logic              id_valid,
    input logic              done,
    input logic              page_ok,
    input logic              crc_ok,
    input logic [SIZE_W-1:0] total_bytes,
    input logic [31:0]       page_bytes,
    input logic              ecc_known,
    input logic              id_done,
    input logic              id_onfi
);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pg_valid));

    // R5
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(page_ok) && $stable(crc_ok) && $stable(total_bytes)));

    // R4
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !page_ok) |-> (page_bytes == '0 && total_bytes == '0 && !ecc_known));

    // R10
    id_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_done |-> ($past(id_valid) && !$past(id_done)));

    // R10
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_done |-> $stable(id_onfi));

endmodule

bind onfi_param_validator onfi_param_validator_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_valid    (pg_valid),
    .id_valid    (id_valid),
    .done        (done),
    .page_ok     (page_ok),
    .crc_ok      (crc_ok),
    .total_bytes (total_bytes),
    .page_bytes  (page_bytes),
    .ecc_known   (ecc_known),
    .id_done     (id_done),
    .id_onfi     (id_onfi)
);

// File: tb/onfi_param_validator_tb.sv
module onfi_param_validator_tb;

    localparam int PAGE_LEN = 256;
    localparam int SIZE_W   = 64;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              pg_valid;
    logic [7:0]        pg_byte;
    logic              id_valid;
    logic [7:0]        id_byte;
    logic              done, page_ok, sig_ok, crc_ok, bus16, ecc_known, id_done, id_onfi;
    logic [31:0]       page_bytes;
    logic [SIZE_W-1:0] block_bytes, total_bytes;
    logic [7:0]        ecc_bits;

    int nvec = 0;
    int nbad = 0;

    logic [7:0]  pg [PAGE_LEN];
    logic        prev_ok = 1'b0;
    logic [63:0] prev_total = '0;
    logic        prev_id = 1'b0;

    always #5 clk = ~clk;

    onfi_param_validator #(.PAGE_LEN(PAGE_LEN), .SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pg_valid(pg_valid), .pg_byte(pg_byte),
        .id_valid(id_valid), .id_byte(id_byte), .done(done), .page_ok(page_ok),
        .sig_ok(sig_ok), .crc_ok(crc_ok), .bus16(bus16), .page_bytes(page_bytes),
        .block_bytes(block_bytes), .total_bytes(total_bytes), .ecc_known(ecc_known),
        .ecc_bits(ecc_bits), .id_done(id_done), .id_onfi(id_onfi));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc();
        logic [15:0] c = 16'h4F4E;
        logic        fb;
        for (int i = 0; i < PAGE_LEN - 2; i++)
            for (int b = 7; b >= 0; b--) begin
                fb = c[15] ^ pg[i][b];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h8005;
            end
        return c;
    endfunction

    function automatic logic [31:0] le32(input int p);
        return {pg[p+3], pg[p+2], pg[p+1], pg[p]};
    endfunction

    task automatic build_page(input logic [31:0] bpp, input logic [31:0] ppb,
                              input logic [31:0] bpl, input logic [7:0] luns,
                              input logic [7:0] ecc, input logic b16);
        logic [15:0] c;
        for (int i = 0; i < PAGE_LEN; i++) pg[i] = 8'($urandom);
        pg[0] = 8'h4F; pg[1] = 8'h4E; pg[2] = 8'h46; pg[3] = 8'h49;
        pg[6][0] = b16;
        for (int k = 0; k < 4; k++) begin
            pg[80+k] = bpp[8*k +: 8];
            pg[92+k] = ppb[8*k +: 8];
            pg[96+k] = bpl[8*k +: 8];
        end
        pg[100] = luns;
        pg[112] = ecc;
        c = ref_crc();
        pg[PAGE_LEN-2] = c[7:0];
        pg[PAGE_LEN-1] = c[15:8];
    endtask

    task automatic send_page(input bit gaps);
        logic e_sig, e_crc, e_ok;
        logic [63:0] e_blk, e_tot;
        for (int i = 0; i < PAGE_LEN; i++) begin
            while (gaps && ($urandom % 4) == 0) begin
                pg_valid = 1'b0; pg_byte = 8'($urandom);
                @(negedge clk);
            end
            if (i == 150) begin
                chk("R5 hold page_ok", page_ok, prev_ok);
                chk("R5 hold total", total_bytes, prev_total);
            end
            pg_valid = 1'b1; pg_byte = pg[i];
            @(negedge clk);
        end
        pg_valid = 1'b0; pg_byte = 8'($urandom);
        e_sig = (pg[0] == 8'h4F) && (pg[1] == 8'h4E) && (pg[2] == 8'h46) && (pg[3] == 8'h49);
        e_crc = (ref_crc() == {pg[PAGE_LEN-1], pg[PAGE_LEN-2]});
        e_ok  = e_sig && e_crc;
        e_blk = 64'(le32(80)) * 64'(le32(92));
        e_tot = e_blk * 64'(le32(96)) * 64'(pg[100]);
        chk("R5 done pulse", done, 1);
        chk("R3 sig_ok", sig_ok, e_sig);
        chk("R2 crc_ok", crc_ok, e_crc);
        chk("R4 page_ok", page_ok, e_ok);
        chk("R6 bus16", bus16, e_ok & pg[6][0]);
        chk("R7 page_bytes", page_bytes, e_ok ? le32(80) : 0);
        chk("R7 block_bytes", block_bytes, e_ok ? e_blk : 0);
        chk("R8 total_bytes", total_bytes, e_ok ? e_tot : 0);
        chk("R9 ecc_known", ecc_known, e_ok && pg[112] != 8'hFF);
        chk("R9 ecc_bits", ecc_bits, (e_ok && pg[112] != 8'hFF) ? pg[112] : 0);
        @(negedge clk);
        chk("R5 done low", done, 0);
        chk("R5 page_ok held", page_ok, e_ok);
        prev_ok = e_ok;
        prev_total = e_ok ? e_tot : 0;
    endtask

    task automatic send_id(input logic [31:0] w, input bit gaps);
        for (int k = 0; k < 4; k++) begin
            while (gaps && ($urandom % 3) == 0) begin
                id_valid = 1'b0; id_byte = 8'($urandom);
                @(negedge clk);
            end
            if (k == 2) chk("R10 id_onfi held", id_onfi, prev_id);
            id_valid = 1'b1; id_byte = w[8*(3-k) +: 8];
            @(negedge clk);
        end
        id_valid = 1'b0; id_byte = 8'($urandom);
        chk("R10 id_done", id_done, 1);
        chk("R10 id_onfi", id_onfi, w == 32'h4F4E4649);
        prev_id = (w == 32'h4F4E4649);
        @(negedge clk);
        chk("R10 id_done low", id_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int seed_set;
        int mode;
        seed_set = $urandom(32'd20240611);
        rst_n = 1'b0; pg_valid = 1'b0; pg_byte = '0; id_valid = 1'b0; id_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", done, 0);
        chk("R1 page_ok", page_ok, 0);
        chk("R1 sig_crc", {sig_ok, crc_ok, bus16, ecc_known}, 0);
        chk("R1 sizes", page_bytes | block_bytes | total_bytes, 0);
        chk("R1 ecc_bits", ecc_bits, 0);
        chk("R1 id", {id_done, id_onfi}, 0);

        // Directed: good page, 16-bit bus, ECC given
        build_page(32'd4096, 32'd64, 32'd2048, 8'd2, 8'd8, 1'b1);
        send_page(1'b0);
        // R9 unspecified ECC, R11 gaps with junk data
        build_page(32'd2048, 32'd128, 32'd1024, 8'd1, 8'hFF, 1'b0);
        send_page(1'b1);
        // R3 bad signature, CRC recomputed so only signature fails
        build_page(32'd512, 32'd32, 32'd100, 8'd1, 8'd4, 1'b1);
        pg[2] = 8'h58;
        {pg[PAGE_LEN-1], pg[PAGE_LEN-2]} = ref_crc();
        send_page(1'b0);
        // R2 stored CRC wrong
        build_page(32'd512, 32'd32, 32'd100, 8'd1, 8'd4, 1'b1);
        pg[PAGE_LEN-1] ^= 8'h01;
        send_page(1'b0);
        // R2 covered body byte flipped
        build_page(32'd8192, 32'd256, 32'd4096, 8'd4, 8'd24, 1'b0);
        pg[200] ^= 8'h10;
        send_page(1'b1);
        // R8 wrap: widest fields
        build_page(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 8'd0, 1'b1);
        send_page(1'b0);

        // Random pages with random corruption (R2, R3, R4, R11)
        for (int n = 0; n < 24; n++) begin
            build_page($urandom % 65536, $urandom % 1024, $urandom % 8192,
                       8'($urandom % 4 + 1), 8'($urandom % 4 == 0 ? 255 : $urandom % 64),
                       1'($urandom));
            mode = $urandom % 4;
            if (mode == 1) pg[$urandom % 4] ^= 8'(($urandom % 255) + 1);
            if (mode == 2) pg[PAGE_LEN-2] ^= 8'(($urandom % 255) + 1);
            if (mode == 3) pg[4 + ($urandom % (PAGE_LEN - 6))] ^= 8'h80;
            send_page(1'($urandom));
        end

        // R10 identification path
        send_id(32'h4F4E4649, 1'b0);
        send_id(32'h004E4649, 1'b1);
        send_id(32'h4F004649, 1'b0);
        send_id(32'h4F4E0049, 1'b1);
        send_id(32'h4F4E4600, 1'b0);
        send_id(32'h4F4E4649, 1'b1);
        for (int n = 0; n < 6; n++) send_id((n % 2 == 0) ? 32'h4F4E4649 : $urandom, 1'($urandom));

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule